// File: doc/BRIEF.md
# Two-Pattern Delay Test Sequencer

This controller steps a grouped scan-tree test structure through a list of two-vector delay tests. Software programs a tree depth `d` and a count of vector pairs, then pulses `start`. For each pair the sequencer first shifts the initial vector into all trees in parallel over `d` shift cycles. It then shifts the second vector over another `d` cycles while the shared hold latches keep the initial vector on the logic inputs. The last step is a single at-speed cycle in which the latches are released. In that cycle the primary-input selection moves to the second vector's bits, so the transition is launched, and the response is captured at the closing edge of the same cycle.

Stimulus words arrive one per shift cycle, one bit per scan-in pin, through a valid/ready handshake. A missing word stalls the sequence without shifting and without counting the cycle. Each captured response leaves the trees while the next pair's initial vector is loaded, and is reported on a strobe together with the compacted word. After the last pair a short flush drains the final response. Without stalls, a run takes vec·(2d+1)+(d−1) clocked cycles.

Top module: `twopat_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the outputs `scan_en`, `hold_en`, `test_mode`, `x1_sel`, `pi_sel`, `stim_ready`, `resp_valid`, `busy` and `done` are all 0.
- R2: `start` in the idle state is accepted only when `cfg_depth` is between 1 and DEPTH_MAX and `cfg_pairs` is at least 1. Any other `start` leaves the block idle. A `start` while busy is ignored, and so are changes to the configuration inputs during a run.
- R3: Every pair runs as `d` shifting cycles for the first vector, then `d` shifting cycles for the second vector, then one fire cycle. Counting cycles with `scan_en` or `x1_sel` high, a whole run totals exactly vec·(2d+1)+(d−1).
- R4: `hold_en` is high on the final shifting cycle of each first-vector load and in each fire cycle, and low in every other cycle.
- R5: In the fire cycle, `scan_en`=0, `test_mode`=0, `hold_en`=1, `x1_sel`=1 and `pi_sel`=1 (1 selects the second vector's primary-input bits). `pi_sel` and `x1_sel` are 0 in every other cycle.
- R6: `stim_ready` is high in every cycle of both vector loads. If `stim_valid` is low in such a cycle, `scan_en`, `hold_en` and `resp_valid` are 0 and the sequence does not advance. When `scan_en` is high, `scan_in` equals `stim_data`; otherwise it is 0.
- R7: `resp_valid` is high on each first-vector shifting cycle of pairs 2 to vec, on each flush cycle, and on the done cycle, which gives vec·d strobes per run. It is low during the first pair's load and during every second-vector load. `resp_data` equals `resp_in` while `resp_valid` is high and is 0 otherwise.
- R8: After the last fire cycle there are `d`−1 flush cycles with `scan_en`=1, `test_mode`=1 and `stim_ready`=0. Then `done` is high for exactly one cycle, and the block returns to idle.
- R9: `busy` is high from the cycle after an accepted `start` through the done cycle, and low in idle. `test_mode` is 1 in load and flush cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with the current configuration |
| cfg_depth | input | $clog2(DEPTH_MAX+1) | Tree depth d |
| cfg_pairs | input | $clog2(PAIR_MAX+1) | Number of vector pairs |
| stim_valid | input | 1 | Stimulus word present |
| stim_data | input | SI_N | Stimulus word, one bit per scan-in pin |
| stim_ready | output | 1 | Sequencer consumes a word when valid |
| scan_in | output | SI_N | Bits driven onto the scan-in pins |
| scan_en | output | 1 | Scan flip-flops shift this cycle |
| hold_en | output | 1 | Hold latches transparent |
| test_mode | output | 1 | Flip-flop data input takes the scan path |
| x1_sel | output | 1 | Extra multiplexers forced to the hold latch |
| pi_sel | output | 1 | 0: first-vector primary inputs, 1: second-vector |
| resp_in | input | RESP_N | Compactor outputs |
| resp_valid | output | 1 | Response word valid |
| resp_data | output | RESP_N | Reported compacted response |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The busiest cycle is a first-vector shift of any pair after the first. In that cycle the block loads new stimulus, strobes out the previous response, and on the last level also opens the hold latches. A stalled stimulus word has to cancel all three together. The bench provokes this by dropping `stim_valid` at random, including on those last-level cycles. Each cycle it compares all outputs against a requirement-level phase model. It also checks that the stall-free cycle total and the strobe total still match vec·(2d+1)+(d−1) and vec·d.

// File: rtl/twopat_pkg.sv
package twopat_pkg;
   typedef enum logic [2:0] {
      TP_IDLE  = 3'd0,
      TP_LOAD1 = 3'd1,
      TP_LOAD2 = 3'd2,
      TP_FIRE  = 3'd3,
      TP_FLUSH = 3'd4,
      TP_DONE  = 3'd5
   } tp_state_e;
endpackage

// File: rtl/twopat_level_ctr.sv
// Shift-level counter: wraps to zero after reaching the limit.
module twopat_level_ctr #(
   parameter int DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [DW-1:0] limit,
   output logic          last
);
   logic [DW-1:0] cnt_q;

   assign last = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : cnt_q + DW'(1);
      end
   end
endmodule

// File: rtl/twopat_pair_ctr.sv
// Vector-pair counter.
module twopat_pair_ctr #(
   parameter int PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [PW-1:0] total,
   output logic          first,
   output logic          last
);
   logic [PW-1:0] cnt_q;

   assign first = (cnt_q == '0);
   assign last  = (cnt_q == total - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + PW'(1);
      end
   end
endmodule

// File: rtl/twopat_fsm.sv
module twopat_fsm
   import twopat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_ok,
   input  logic      stim_valid,
   input  logic      lvl_last,
   input  logic      pair_last,
   input  logic      multi_level,
   output tp_state_e state
);
   tp_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         TP_IDLE:  if (start_ok) nxt = TP_LOAD1;
         TP_LOAD1: if (stim_valid && lvl_last) nxt = TP_LOAD2;
         TP_LOAD2: if (stim_valid && lvl_last) nxt = TP_FIRE;
         TP_FIRE: begin
            if (!pair_last)       nxt = TP_LOAD1;
            else if (multi_level) nxt = TP_FLUSH;
            else                  nxt = TP_DONE;
         end
         TP_FLUSH: if (lvl_last) nxt = TP_DONE;
         TP_DONE:  nxt = TP_IDLE;
         default:  nxt = TP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= TP_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/twopat_decode.sv
// Control decode; stall gating happens here so every shift-side output drops together.
module twopat_decode
   import twopat_pkg::*;
(
   input  tp_state_e state,
   input  logic      stim_valid,
   input  logic      lvl_last,
   input  logic      first_pair,
   output logic      shift,
   output logic      hold,
   output logic      tmode,
   output logic      x1,
   output logic      pisel,
   output logic      ready,
   output logic      rvalid,
   output logic      busy_o,
   output logic      done_o
);
   logic loading;

   assign loading = (state == TP_LOAD1) || (state == TP_LOAD2);

   always_comb begin
      ready  = loading;
      tmode  = loading || (state == TP_FLUSH);
      shift  = (loading && stim_valid) || (state == TP_FLUSH);
      x1     = (state == TP_FIRE);
      pisel  = (state == TP_FIRE);
      hold   = (state == TP_FIRE) ||
               ((state == TP_LOAD1) && stim_valid && lvl_last);
      rvalid = ((state == TP_LOAD1) && stim_valid && !first_pair) ||
               (state == TP_FLUSH) || (state == TP_DONE);
      busy_o = (state != TP_IDLE);
      done_o = (state == TP_DONE);
   end
endmodule

// File: rtl/twopat_seq.sv
module twopat_seq
   import twopat_pkg::*;
#(
   parameter int SI_N         = 4,
   parameter int RESP_N       = 3,
   parameter int DEPTH_MAX    = 64,
   parameter int PAIR_MAX     = 1023,
   parameter bit ZERO_IDLE_SI = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [$clog2(DEPTH_MAX+1)-1:0]    cfg_depth,
   input  logic [$clog2(PAIR_MAX+1)-1:0]     cfg_pairs,
   input  logic                              stim_valid,
   input  logic [SI_N-1:0]                   stim_data,
   output logic                              stim_ready,
   output logic [SI_N-1:0]                   scan_in,
   output logic                              scan_en,
   output logic                              hold_en,
   output logic                              test_mode,
   output logic                              x1_sel,
   output logic                              pi_sel,
   input  logic [RESP_N-1:0]                 resp_in,
   output logic                              resp_valid,
   output logic [RESP_N-1:0]                 resp_data,
   output logic                              busy,
   output logic                              done
);
   localparam int DW = $clog2(DEPTH_MAX + 1);
   localparam int PW = $clog2(PAIR_MAX + 1);

   generate
      if (SI_N < 1) begin : g_bad_si
         $error("SI_N must be at least 1");
      end
      if (RESP_N < 1) begin : g_bad_resp
         $error("RESP_N must be at least 1");
      end
      if (DEPTH_MAX < 1) begin : g_bad_depth
         $error("DEPTH_MAX must be at least 1");
      end
      if (PAIR_MAX < 1) begin : g_bad_pairs
         $error("PAIR_MAX must be at least 1");
      end
   endgenerate

   tp_state_e     state;
   logic [DW-1:0] depth_q;
   logic [PW-1:0] pairs_q;
   logic [DW-1:0] lvl_limit;
   logic          start_ok;
   logic          lvl_last;
   logic          pair_last;
   logic          first_pair;

   assign start_ok = start && (state == TP_IDLE) &&
                     (cfg_depth != '0) && (cfg_depth <= DW'(DEPTH_MAX)) &&
                     (cfg_pairs != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= DW'(1);
         pairs_q <= PW'(1);
      end else if (start_ok) begin
         depth_q <= cfg_depth;
         pairs_q <= cfg_pairs;
      end
   end

   // Flush drains one level fewer than a load.
   assign lvl_limit = (state == TP_FLUSH) ? depth_q - DW'(2) : depth_q - DW'(1);

   twopat_level_ctr #(.DW(DW)) lvl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .step  (scan_en),
      .limit (lvl_limit),
      .last  (lvl_last)
   );

   twopat_pair_ctr #(.PW(PW)) pair_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .step  (x1_sel),
      .total (pairs_q),
      .first (first_pair),
      .last  (pair_last)
   );

   twopat_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ok    (start_ok),
      .stim_valid  (stim_valid),
      .lvl_last    (lvl_last),
      .pair_last   (pair_last),
      .multi_level (depth_q != DW'(1)),
      .state       (state)
   );

   twopat_decode dec_i (
      .state      (state),
      .stim_valid (stim_valid),
      .lvl_last   (lvl_last),
      .first_pair (first_pair),
      .shift      (scan_en),
      .hold       (hold_en),
      .tmode      (test_mode),
      .x1         (x1_sel),
      .pisel      (pi_sel),
      .ready      (stim_ready),
      .rvalid     (resp_valid),
      .busy_o     (busy),
      .done_o     (done)
   );

   assign resp_data = resp_valid ? resp_in : '0;

   generate
      if (ZERO_IDLE_SI) begin : g_si_gated
         assign scan_in = scan_en ? stim_data : '0;
      end else begin : g_si_open
         assign scan_in = stim_data;
      end
   endgenerate
endmodule

// File: rtl/twopat_seq_chk.sv
module twopat_seq_chk #(
   parameter int DW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [DW-1:0] cfg_depth,
   input logic          stim_valid,
   input logic          stim_ready,
   input logic          scan_en,
   input logic          hold_en,
   input logic          test_mode,
   input logic          x1_sel,
   input logic          pi_sel,
   input logic          resp_valid,
   input logic          busy,
   input logic          done
);
   // R6
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stim_ready && !stim_valid) |-> (!scan_en && !hold_en && !resp_valid));

   // R5
   fire_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x1_sel |-> (!scan_en && !test_mode && hold_en && pi_sel));

   // R3
   fire_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x1_sel |-> $past(scan_en));

   // R4
   hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && !x1_sel) |=> !hold_en);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R2
   bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && cfg_depth == '0) |=> !busy);
endmodule

bind twopat_seq twopat_seq_chk #(.DW($clog2(DEPTH_MAX+1))) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cfg_depth  (cfg_depth),
   .stim_valid (stim_valid),
   .stim_ready (stim_ready),
   .scan_en    (scan_en),
   .hold_en    (hold_en),
   .test_mode  (test_mode),
   .x1_sel     (x1_sel),
   .pi_sel     (pi_sel),
   .resp_valid (resp_valid),
   .busy       (busy),
   .done       (done)
);

// File: tb/twopat_seq_tb_top.sv
`timescale 1ns/1ps
module twopat_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] cfg_depth = '0;
   logic [9:0] cfg_pairs = '0;
   logic       stim_valid = 1'b0;
   logic [3:0] stim_data = '0;
   logic [2:0] resp_in = '0;
   logic       stim_ready, scan_en, hold_en, test_mode, x1_sel, pi_sel;
   logic       resp_valid, busy, done;
   logic [3:0] scan_in;
   logic [2:0] resp_data;

   int errors = 0;
   int checks = 0;

   // bench phase model: 0 idle, 1 first load, 2 second load, 3 fire, 4 flush, 5 done
   int m_ph = 0, m_k = 0, m_pc = 0, m_d = 1, m_v = 1;

   always #4 clk = ~clk;

   twopat_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_depth(cfg_depth),
      .cfg_pairs(cfg_pairs), .stim_valid(stim_valid), .stim_data(stim_data),
      .stim_ready(stim_ready), .scan_in(scan_in), .scan_en(scan_en),
      .hold_en(hold_en), .test_mode(test_mode), .x1_sel(x1_sel),
      .pi_sel(pi_sel), .resp_in(resp_in), .resp_valid(resp_valid),
      .resp_data(resp_data), .busy(busy), .done(done)
   );

   function automatic string bit_req(input int b);
      case (b)
         8: return "R3";
         7: return "R4";
         6, 5, 4: return "R5";
         3: return "R6";
         2: return "R7";
         0: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [8:0] model_out(input logic sv);
      logic [8:0] e;
      e = '0;
      case (m_ph)
         1: begin
            e[3] = 1; e[6] = 1; e[1] = 1;
            if (sv) begin
               e[8] = 1;
               e[7] = (m_k == m_d - 1);
               e[2] = (m_pc != 0);
            end
         end
         2: begin
            e[3] = 1; e[6] = 1; e[1] = 1;
            if (sv) e[8] = 1;
         end
         3: begin e[7] = 1; e[5] = 1; e[4] = 1; e[1] = 1; end
         4: begin e[8] = 1; e[6] = 1; e[2] = 1; e[1] = 1; end
         5: begin e[2] = 1; e[1] = 1; e[0] = 1; end
         default: e = '0;
      endcase
      return e;
   endfunction

   task automatic model_step(input logic sv, input logic st, input int d_in, input int v_in);
      case (m_ph)
         0: if (st && d_in >= 1 && d_in <= 64 && v_in >= 1) begin
            m_ph = 1; m_k = 0; m_pc = 0; m_d = d_in; m_v = v_in;
         end
         1, 2: if (sv) begin
            if (m_k == m_d - 1) begin m_ph = m_ph + 1; m_k = 0; end
            else m_k = m_k + 1;
         end
         3: begin
            m_k = 0;
            if (m_pc == m_v - 1) m_ph = (m_d > 1) ? 4 : 5;
            else begin m_ph = 1; m_pc = m_pc + 1; end
         end
         4: if (m_k == m_d - 2) m_ph = 5; else m_k = m_k + 1;
         default: m_ph = 0;
      endcase
   endtask

   // drive one cycle at negedge, compare before the next posedge, then advance the model
   task automatic one_cycle(input string tag, input logic st, input int d_in, input int v_in,
                            input int stall_pct, inout int active, inout int strobes);
      logic [8:0] act, exp;
      logic sv;
      @(negedge clk);
      sv = (($urandom % 100) >= stall_pct);
      start = st; cfg_depth = 7'(d_in); cfg_pairs = 10'(v_in);
      stim_valid = sv; stim_data = 4'($urandom); resp_in = 3'($urandom);
      #2;
      act = {scan_en, hold_en, test_mode, x1_sel, pi_sel, stim_ready, resp_valid, busy, done};
      exp = model_out(sv);
      checks++;
      if (act !== exp) begin
         int b = 8;
         while (b > 0 && act[b] === exp[b]) b--;
         errors++;
         $display("FAIL %s %s: outputs %b expected %b", tag, bit_req(b), act, exp);
      end
      checks++;
      if (scan_in !== (scan_en ? stim_data : 4'h0) ||
          resp_data !== (resp_valid ? resp_in : 3'h0)) begin
         errors++;
         $display("FAIL %s R6/R7 data: scan_in %h resp_data %h expected %h %h", tag,
                  scan_in, resp_data, scan_en ? stim_data : 4'h0, resp_valid ? resp_in : 3'h0);
      end
      if (scan_en || x1_sel) active++;
      if (resp_valid) strobes++;
      model_step(sv, st, d_in, v_in);
   endtask

   task automatic run_case(input int d, input int v, input int stall_pct, input bit poke_busy);
      int act = 0, strb = 0, act_free = 0, n = 0;
      string tag;
      tag = $sformatf("d=%0d vec=%0d", d, v);
      one_cycle(tag, 1'b1, d, v, 0, act, strb);
      while (m_ph != 0 && n < 20000) begin
         logic st = poke_busy && (n == 2);
         one_cycle(tag, st, st ? 3 : d, st ? 2 : v, stall_pct, act, strb);
         n++;
      end
      act_free = v * (2 * d + 1) + (d - 1);
      checks++;
      if (act != act_free) begin
         errors++;
         $display("FAIL R3 %s: active cycles %0d expected %0d", tag, act, act_free);
      end
      checks++;
      if (strb != v * d) begin
         errors++;
         $display("FAIL R7 %s: strobes %0d expected %0d", tag, strb, v * d);
      end
      for (int i = 0; i < 2; i++) one_cycle(tag, 1'b0, d, v, 0, act, strb);
   endtask

   task automatic bad_start(input int d, input int v);
      int a = 0, s = 0;
      // R2: rejected configuration leaves every output idle
      one_cycle("R2 reject", 1'b1, d, v, 0, a, s);
      for (int i = 0; i < 3; i++) one_cycle("R2 reject", 1'b0, d, v, 0, a, s);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      checks++;
      if ({scan_en, hold_en, test_mode, x1_sel, pi_sel, stim_ready, resp_valid, busy, done} !== 9'b0) begin
         errors++;
         $display("FAIL R1: outputs %b expected 0", {scan_en, hold_en, test_mode, x1_sel,
                  pi_sel, stim_ready, resp_valid, busy, done});
      end
      rst_n = 1'b1;
      bad_start(0, 3);
      bad_start(4, 0);
      bad_start(65, 2);
      run_case(1, 1, 0, 0);
      run_case(1, 3, 30, 0);
      run_case(2, 2, 0, 0);
      run_case(5, 3, 25, 1);
      run_case(8, 2, 40, 0);
      run_case(64, 2, 10, 0);
      for (int i = 0; i < 4; i++)
         run_case(1 + int'($urandom % 12), 1 + int'($urandom % 5), int'($urandom % 50), 1'($urandom));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule